// File: doc/BRIEF.md
# Bus Master Burst Tenure Timer

This block limits how long a bridge, acting as master on its secondary bus, keeps a burst going once another agent wants the bus. A configuration register holds the allowed tenure in steps of eight bus clocks. When the master starts a transaction, the block loads a down-counter from that register. The counter then counts down once per clock and holds at zero. After the count has run out, the block raises a terminate request to the master state machine, but only when the arbiter has taken the grant away. While the grant is still held, the master may keep the bus for as long as it likes.

The reset value of the register comes from a mode strap. On a conventional bus the tenure is zero. On an extended bus the register resets to 40h, which is 64 clocks. The terminate request is a registered level. Once it is set, it stays set until the master drops its transaction.

Top module: `bus_tenure_timer`

## Requirements
- R1: A configuration write stores write-data bits 7:3 as the tenure field, and the read port shows the new value from the cycle after the write; with no write the field is unchanged.
- R2: Read-data bits 2:0 always read as zero, whatever value was written to them.
- R3: While reset is held, the register takes 00h when `ext_mode_strap` is 0 and 40h when it is 1.
- R4: `frame_start` high at a clock edge loads the down-counter with field × 8; a write to the register during a burst does not alter the count already loaded.
- R5: With the grant low, `end_burst` first reads high after the (8·F+1)-th clock edge that follows the edge sampling `frame_start`, where F is the field value; F = 0 gives one edge.
- R6: While `gnt` stays high, `end_burst` stays low, even long after the count has run out.
- R7: When `gnt` falls after the count has run out and `frame_active` is high, `end_burst` is high after the very next clock edge.
- R8: Once high, `end_burst` stays high, even if `gnt` returns, until an edge samples `frame_active` low; after that edge it reads low.
- R9: `end_burst` is never set by an edge at which `frame_active` is low, and a new `frame_start` reloads the counter and clears any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Secondary bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode_strap | input | 1 | Bus mode strap: 0 conventional, 1 extended; read during reset |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 8 | Configuration write data |
| cfg_rd_data | output | 8 | Configuration register read value |
| frame_start | input | 1 | One-cycle pulse when the master asserts FRAME# |
| frame_active | input | 1 | High while the master's FRAME# is asserted |
| gnt | input | 1 | Bus grant from the arbiter, active high |
| end_burst | output | 1 | Registered request to end the current burst |

## Verification
The hardest case to reach is a grant that is withdrawn only after the count has already run out, followed by a grant that comes back while the request is pending. To get there, the bench holds the grant high for well past the programmed tenure. It then drops the grant for a single cycle and raises it again, checking the request edge by edge. It also sweeps every one of the 32 field values with the grant low and compares the exact edge at which the request rises against 8·F+1.

// File: rtl/tenure_pkg.sv
package tenure_pkg;

   typedef enum logic {
      BUS_CONVENTIONAL = 1'b0,
      BUS_EXTENDED     = 1'b1
   } bus_mode_e;

   // number of clocks granted by a field value and a unit exponent
   function automatic int unsigned tenure_clocks(input int unsigned field,
                                                 input int unsigned unit_log2);
      return field << unit_log2;
   endfunction

endpackage

// File: rtl/tenure_cfg_reg.sv
module tenure_cfg_reg
   import tenure_pkg::*;
#(
   parameter int unsigned FIELD_W   = 5,
   parameter int unsigned UNIT_LOG2 = 3,
   parameter int unsigned CONV_RST  = 0,
   parameter int unsigned EXT_RST   = 8,
   localparam int unsigned REG_W    = FIELD_W + UNIT_LOG2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_strap,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   output logic [FIELD_W-1:0] field_o,
   output logic [REG_W-1:0]   rd_data_o
);

   localparam logic [FIELD_W-1:0] CONV_VAL = FIELD_W'(CONV_RST);
   localparam logic [FIELD_W-1:0] EXT_VAL  = FIELD_W'(EXT_RST);

   if (FIELD_W < 1) begin : g_bad_field
      $error("tenure_cfg_reg: FIELD_W must be at least 1");
   end
   if (CONV_RST >= (1 << FIELD_W) || EXT_RST >= (1 << FIELD_W)) begin : g_bad_rst
      $error("tenure_cfg_reg: reset field values exceed field width");
   end

   bus_mode_e    mode;
   logic [FIELD_W-1:0] field_q;

   assign mode = bus_mode_e'(mode_strap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q <= (mode == BUS_EXTENDED) ? EXT_VAL : CONV_VAL;
      end else if (wr_en) begin
         field_q <= wr_data[REG_W-1:UNIT_LOG2];
      end
   end

   assign field_o = field_q;

   // read view: field in the upper bits, fixed zeros below
   for (genvar b = 0; b < REG_W; b++) begin : g_rd
      if (b < UNIT_LOG2) begin : g_ro
         assign rd_data_o[b] = 1'b0;
      end else begin : g_rw
         assign rd_data_o[b] = field_q[b-UNIT_LOG2];
      end
   end

   p_write_takes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> field_o == $past(wr_data[REG_W-1:UNIT_LOG2]));

   p_hold_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(field_o));

endmodule

// File: rtl/tenure_counter.sv
module tenure_counter #(
   parameter int unsigned FIELD_W   = 5,
   parameter int unsigned UNIT_LOG2 = 3,
   localparam int unsigned CNT_W    = FIELD_W + UNIT_LOG2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic [FIELD_W-1:0] field_i,
   output logic               expired_o
);

   if (CNT_W > 30) begin : g_bad_cnt
      $error("tenure_counter: counter too wide");
   end

   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt_q;

   if (UNIT_LOG2 == 0) begin : g_unit1
      assign load_val = field_i;
   end else begin : g_unitn
      assign load_val = {field_i, {UNIT_LOG2{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_q == $past(load_val));

   p_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && !load_i) |=> expired_o);

   p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!expired_o && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/tenure_term_ctl.sv
module tenure_term_ctl #(
   parameter bit HOLD_TERM = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_active_i,
   input  logic frame_start_i,
   input  logic gnt_i,
   input  logic expired_i,
   output logic term_o
);

   logic set_term;
   logic term_d;
   logic term_q;

   assign set_term = expired_i && !gnt_i && !frame_start_i;

   if (HOLD_TERM) begin : g_hold
      assign term_d = frame_active_i && !frame_start_i && (term_q || set_term);
   end else begin : g_follow
      assign term_d = frame_active_i && set_term;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) term_q <= 1'b0;
      else        term_q <= term_d;
   end

   assign term_o = term_q;

   p_grant_keeps_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!term_o && gnt_i) |=> !term_o);

   p_drop_after_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_active_i && !frame_start_i && expired_i && !gnt_i) |=> term_o);

   p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_active_i |=> !term_o);

   p_new_frame_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_i |=> !term_o);

   if (HOLD_TERM) begin : g_hold_chk
      p_level_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (term_o && frame_active_i && !frame_start_i) |=> term_o);
   end

endmodule

// File: rtl/bus_tenure_timer.sv
module bus_tenure_timer #(
   parameter int unsigned FIELD_W   = 5,
   parameter int unsigned UNIT_LOG2 = 3,
   parameter int unsigned CONV_RST  = 0,
   parameter int unsigned EXT_RST   = 8,
   parameter bit          HOLD_TERM = 1'b1,
   localparam int unsigned REG_W    = FIELD_W + UNIT_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_mode_strap,
   input  logic             cfg_wr_en,
   input  logic [REG_W-1:0] cfg_wr_data,
   output logic [REG_W-1:0] cfg_rd_data,
   input  logic             frame_start,
   input  logic             frame_active,
   input  logic             gnt,
   output logic             end_burst
);

   logic [FIELD_W-1:0] field;
   logic               expired;

   tenure_cfg_reg #(
      .FIELD_W  (FIELD_W),
      .UNIT_LOG2(UNIT_LOG2),
      .CONV_RST (CONV_RST),
      .EXT_RST  (EXT_RST)
   ) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_strap(ext_mode_strap),
      .wr_en     (cfg_wr_en),
      .wr_data   (cfg_wr_data),
      .field_o   (field),
      .rd_data_o (cfg_rd_data)
   );

   tenure_counter #(
      .FIELD_W  (FIELD_W),
      .UNIT_LOG2(UNIT_LOG2)
   ) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (frame_start),
      .field_i  (field),
      .expired_o(expired)
   );

   tenure_term_ctl #(
      .HOLD_TERM(HOLD_TERM)
   ) i_term (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_active_i(frame_active),
      .frame_start_i (frame_start),
      .gnt_i         (gnt),
      .expired_i     (expired),
      .term_o        (end_burst)
   );

   p_no_term_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(end_burst) |-> $past(frame_active));

endmodule

// File: tb/test_bus_tenure_timer.sv
module test_bus_tenure_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_mode_strap = 1'b0;
   logic       cfg_wr_en = 1'b0;
   logic [7:0] cfg_wr_data = '0;
   logic [7:0] cfg_rd_data;
   logic       frame_start = 1'b0;
   logic       frame_active = 1'b0;
   logic       gnt = 1'b1;
   logic       end_burst;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bus_tenure_timer i_bus_tenure_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .ext_mode_strap(ext_mode_strap),
      .cfg_wr_en     (cfg_wr_en),
      .cfg_wr_data   (cfg_wr_data),
      .cfg_rd_data   (cfg_rd_data),
      .frame_start   (frame_start),
      .frame_active  (frame_active),
      .gnt           (gnt),
      .end_burst     (end_burst)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_reset(input logic strap);
      rst_n = 1'b0;
      ext_mode_strap = strap;
      frame_start = 1'b0;
      frame_active = 1'b0;
      cfg_wr_en = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic write_cfg(input logic [7:0] d);
      cfg_wr_en = 1'b1;
      cfg_wr_data = d;
      step();
      cfg_wr_en = 1'b0;
   endtask

   // begin a frame; returns at the negedge right after the sampling edge
   task automatic start_frame();
      frame_active = 1'b1;
      frame_start = 1'b1;
      step();
      frame_start = 1'b0;
   endtask

   task automatic end_frame(input string req);
      frame_active = 1'b0;
      step();
      chk(req, {7'd0, end_burst}, 8'd0);
   endtask

   // grant low throughout: request must rise after edge 8*F+1
   task automatic expiry_run(input int f, input string req);
      int target;
      target = 8 * f + 1;
      gnt = 1'b0;
      start_frame();
      chk(req, {7'd0, end_burst}, 8'd0);
      for (int k = 1; k <= target + 2; k++) begin
         step();
         chk(req, {7'd0, end_burst}, {7'd0, (k >= target)});
      end
   endtask

   initial begin
      // R3: reset value in extended mode
      do_reset(1'b1);
      chk("R3", cfg_rd_data, 8'h40);
      chk("R9", {7'd0, end_burst}, 8'd0);
      // R5: default 64-clock tenure
      expiry_run(8, "R5");
      end_frame("R8");

      // R3: reset value in conventional mode
      do_reset(1'b0);
      chk("R3", cfg_rd_data, 8'h00);
      // R5: zero tenure expires at once
      expiry_run(0, "R5");
      end_frame("R8");

      // R1 R2 R5: sweep every field value
      for (int v = 0; v < 32; v++) begin
         write_cfg({5'(v), 3'b101});
         chk("R1", {3'd0, cfg_rd_data[7:3]}, 8'(v));
         chk("R2", {5'd0, cfg_rd_data[2:0]}, 8'd0);
         expiry_run(v, "R5");
         end_frame("R8");
      end

      // R1: no write leaves the register unchanged
      cfg_wr_data = 8'hA8;
      repeat (2) step();
      chk("R1", cfg_rd_data, 8'hF8);

      // R6 R7 R8: grant held past expiry, then dropped for one cycle
      write_cfg(8'h18);   // F=3, 24 clocks
      gnt = 1'b1;
      start_frame();
      for (int k = 1; k <= 40; k++) begin
         step();
         chk("R6", {7'd0, end_burst}, 8'd0);
      end
      gnt = 1'b0;
      step();
      chk("R7", {7'd0, end_burst}, 8'd1);
      gnt = 1'b1;
      repeat (3) begin
         step();
         chk("R8", {7'd0, end_burst}, 8'd1);
      end
      end_frame("R8");

      // R4: write during a burst does not change the loaded count
      write_cfg(8'h20);   // F=4, 32 clocks
      gnt = 1'b0;
      start_frame();
      write_cfg(8'h08);   // taken by the register, not by the running count
      for (int k = 2; k <= 34; k++) begin
         step();
         chk("R4", {7'd0, end_burst}, {7'd0, (k >= 33)});
      end
      end_frame("R8");

      // R5: grant dropped before expiry, request still waits for the count
      write_cfg(8'h10);   // F=2, 16 clocks
      gnt = 1'b1;
      start_frame();
      repeat (5) step();
      gnt = 1'b0;
      for (int k = 6; k <= 19; k++) begin
         step();
         chk("R5", {7'd0, end_burst}, {7'd0, (k >= 17)});
      end

      // R9: new frame clears request and reloads the counter
      start_frame();
      chk("R9", {7'd0, end_burst}, 8'd0);
      for (int k = 1; k <= 18; k++) begin
         step();
         chk("R9", {7'd0, end_burst}, {7'd0, (k >= 17)});
      end
      end_frame("R8");

      // R9: counter expired, grant low, but no frame: no request
      repeat (6) begin
         step();
         chk("R9", {7'd0, end_burst}, 8'd0);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule